// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. Software arms it with an enable bit and requests one conversion with a start bit. The sequencer then opens a timed sample window by holding a sample/hold control high. It closes the window and spends one settling tick on the most significant trial code. After that it decides one bit per tick against a comparator input. The finished code goes into a result register.

A conversion is either 10-bit or 8-bit, one channel at a time. The sample window has four selectable lengths. All sequencing runs on a tick taken from the input clock through a divider of 1 to 8. The channel number is latched when the conversion starts and is held on an output for the analog multiplexer. The analog parts (DAC, comparator, reference) sit outside the block, and the bench stands in for them with an ideal comparison.

Top module: `sar_seq`

## Requirements
- R1: A conversion is accepted on a clock edge where `conv_en` and `conv_start` are both 1 and `busy` is 0. `busy` reads 1 after that edge. With `conv_en` at 0, `conv_start` has no effect and `busy` stays 0.
- R2: `busy` stays high for exactly (W + 1 + N) × D clock cycles. W = 4 << `samp_sel` (code 0→4, 1→8, 2→16, 3→32 ticks). N = 10 when `res_sel`=1 and 8 when `res_sel`=0. D = `div_sel` + 1, which ranges from 1 to 8.
- R3: `sh_ctrl` goes high together with `busy` and stays high for exactly W × D cycles. It is never high while `busy` is low.
- R4: Bits are decided MSB first. A trial bit is kept when `cmp_ge` is 1 (input ≥ `trial_code`) and cleared otherwise. In 10-bit mode the result equals the ideal input code, so a full-scale input gives 1023 and a zero input gives 0.
- R5: In 8-bit mode, trials are placed on `trial_code[9:2]` with bits [1:0] at 0. The result is right-justified as input[9:2], and `result[9:8]` is 0.
- R6: `result` changes only on the edge where the last bit is decided. On that same edge `busy` falls and `done` rises. `done` is high for exactly one cycle.
- R7: A `conv_start` pulse while `busy` is 1 is ignored. It does not change the duration, the result or the latched channel.
- R8: `chan_out` takes the value of `chan_sel` at acceptance and holds it until the next accepted conversion.
- R9: After synchronous reset, `busy`, `sh_ctrl`, `done`, `result`, `trial_code` and `chan_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en | input | 1 | Conversion enable |
| conv_start | input | 1 | Start request |
| samp_sel | input | 2 | Sample window select, W = 4 << code ticks |
| res_sel | input | 1 | 1 = 10-bit, 0 = 8-bit |
| div_sel | input | 3 | Tick divider, divide by code + 1 |
| chan_sel | input | 4 | Channel to convert |
| cmp_ge | input | 1 | Comparator: analog input ≥ trial code |
| sh_ctrl | output | 1 | Sample/hold control, 1 = sampling |
| trial_code | output | 10 | Trial code to the DAC |
| chan_out | output | 4 | Latched channel for the multiplexer |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 10 | Conversion result |

## Verification
The bench measures the busy and sample widths at the divider's extremes and at all four window codes. An off-by-one tick in the divider or window counter shows up as a count off by D. Inputs of 0, full scale and alternating bit patterns are converted in both resolutions. A design that took the wrong decision polarity, scanned LSB first, or left-justified the 8-bit result would return a wrong code for these inputs. Start pulses and channel changes are injected mid-conversion to catch a sequencer that restarts or relatches. The result is watched on every busy cycle, which catches early or partial writes.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_HOLD   = 2'd2,
    ST_DECIDE = 2'd3
  } sar_state_t;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic [DIVW-1:0] div_q,
  output logic            tick
);
  logic [DIVW-1:0] cnt;

  assign tick = (cnt == div_q);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int NBITS = 10,
  parameter int LOWBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             commit,
  input  logic             res8,
  input  logic             cmp_ge,
  output logic             last,
  output logic [NBITS-1:0] code,
  output logic [NBITS-1:0] result
);
  localparam int SHIFT = NBITS - LOWBITS;
  localparam logic [NBITS-1:0] MSB = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] mask;
  logic [NBITS-1:0] kept;
  logic [NBITS-1:0] nmask;

  assign kept  = cmp_ge ? code : (code & ~mask);
  assign nmask = mask >> 1;
  assign last  = res8 ? mask[SHIFT] : mask[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask   <= '0;
      code   <= '0;
      result <= '0;
    end else if (load) begin
      mask <= MSB;
      code <= MSB;
    end else if (commit) begin
      result <= res8 ? (kept >> SHIFT) : kept;
      mask   <= '0;
      code   <= '0;
    end else if (step) begin
      mask <= nmask;
      code <= kept | nmask;
    end
  end

  // R4: exactly one bit under trial at a time
  p_mask_onehot_r4: assert property (@(posedge clk) disable iff (rst) $onehot0(mask));
  // R6: result only moves on the commit edge
  p_result_hold_r6: assert property (@(posedge clk) disable iff (rst) !commit |=> $stable(result));
  // R5: right-justified 8-bit result leaves the top bits clear
  p_res8_top_r5: assert property (@(posedge clk) disable iff (rst)
    commit && res8 |=> result[NBITS-1 -: SHIFT] == '0);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int SSW = 2,
  parameter int SAMP_BASE_LOG2 = 2,
  parameter int DIVW = 3,
  parameter int CHW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            conv_en,
  input  logic            conv_start,
  input  logic [SSW-1:0]  samp_sel,
  input  logic            res_sel,
  input  logic [DIVW-1:0] div_sel,
  input  logic [CHW-1:0]  chan_sel,
  input  logic            tick,
  input  logic            last,
  output logic            go,
  output logic            load,
  output logic            step,
  output logic            commit,
  output logic            res8_q,
  output logic [DIVW-1:0] div_q,
  output logic [CHW-1:0]  chan_q,
  output logic            busy,
  output logic            sh_ctrl,
  output logic            done
);
  localparam int MAXWIN_LOG2 = SAMP_BASE_LOG2 + (1 << SSW) - 1;
  localparam int SCW = MAXWIN_LOG2 + 1;

  sar_state_t     st;
  logic [SSW-1:0] ssel_q;
  logic [SCW-1:0] scnt;
  logic [SCW-1:0] win_m1;
  logic           win_end;

  assign win_m1  = SCW'((32'd1 << (SAMP_BASE_LOG2 + 32'(ssel_q))) - 32'd1);
  assign win_end = (st == ST_SAMPLE) && tick && (scnt == win_m1);
  assign go      = conv_en && conv_start && (st == ST_IDLE);
  assign load    = win_end;
  assign step    = (st == ST_DECIDE) && tick;
  assign commit  = step && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ssel_q  <= '0;
      scnt    <= '0;
      res8_q  <= 1'b0;
      div_q   <= '0;
      chan_q  <= '0;
      busy    <= 1'b0;
      sh_ctrl <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (go) begin
          st      <= ST_SAMPLE;
          ssel_q  <= samp_sel;
          res8_q  <= !res_sel;
          div_q   <= div_sel;
          chan_q  <= chan_sel;
          scnt    <= '0;
          busy    <= 1'b1;
          sh_ctrl <= 1'b1;
        end
        ST_SAMPLE: if (tick) begin
          if (win_end) begin
            st      <= ST_HOLD;
            sh_ctrl <= 1'b0;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        ST_HOLD: if (tick) st <= ST_DECIDE;
        ST_DECIDE: if (commit) begin
          st   <= ST_IDLE;
          busy <= 1'b0;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: sampling never outside a conversion
  p_sh_in_busy_r3: assert property (@(posedge clk) disable iff (rst) sh_ctrl |-> busy);
  // R6: done marks the cycle busy has just fallen
  p_done_edge_r6: assert property (@(posedge clk) disable iff (rst) done |-> !busy && $past(busy));
  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7, R8: channel frozen for the whole conversion
  p_chan_hold_r8: assert property (@(posedge clk) disable iff (rst) busy && $past(busy) |-> $stable(chan_q));
  // R1: accepted request starts sampling on the next edge
  p_start_r1: assert property (@(posedge clk) disable iff (rst) go |=> busy && sh_ctrl);
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS = 10,
  parameter int LOWBITS = 8,
  parameter int SSW = 2,
  parameter int SAMP_BASE_LOG2 = 2,
  parameter int DIVW = 3,
  parameter int CHW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_en,
  input  logic             conv_start,
  input  logic [SSW-1:0]   samp_sel,
  input  logic             res_sel,
  input  logic [DIVW-1:0]  div_sel,
  input  logic [CHW-1:0]   chan_sel,
  input  logic             cmp_ge,
  output logic             sh_ctrl,
  output logic [NBITS-1:0] trial_code,
  output logic [CHW-1:0]   chan_out,
  output logic             busy,
  output logic             done,
  output logic [NBITS-1:0] result
);
  logic            tick, last, go, load, step, commit, res8_q;
  logic [DIVW-1:0] div_q;

  sar_clkdiv #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst(rst), .restart(go), .div_q(div_q), .tick(tick)
  );

  sar_ctrl #(
    .SSW(SSW), .SAMP_BASE_LOG2(SAMP_BASE_LOG2), .DIVW(DIVW), .CHW(CHW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .conv_en(conv_en), .conv_start(conv_start),
    .samp_sel(samp_sel), .res_sel(res_sel), .div_sel(div_sel),
    .chan_sel(chan_sel), .tick(tick), .last(last), .go(go), .load(load),
    .step(step), .commit(commit), .res8_q(res8_q), .div_q(div_q),
    .chan_q(chan_out), .busy(busy), .sh_ctrl(sh_ctrl), .done(done)
  );

  sar_reg #(.NBITS(NBITS), .LOWBITS(LOWBITS)) u_reg (
    .clk(clk), .rst(rst), .load(load), .step(step), .commit(commit),
    .res8(res8_q), .cmp_ge(cmp_ge), .last(last), .code(trial_code),
    .result(result)
  );
endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_en = 1'b0, conv_start = 1'b0, res_sel = 1'b1;
  logic [1:0] samp_sel = 2'd0;
  logic [2:0] div_sel = 3'd0;
  logic [3:0] chan_sel = 4'd0;
  logic [9:0] vin = 10'd0;
  logic       cmp_ge;
  logic       sh_ctrl, busy, done;
  logic [9:0] trial_code, result;
  logic [3:0] chan_out;

  int n_checks = 0, n_fail = 0, cycles = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  assign cmp_ge = (vin >= trial_code);

  sar_seq uut (
    .clk(clk), .rst(rst), .conv_en(conv_en), .conv_start(conv_start),
    .samp_sel(samp_sel), .res_sel(res_sel), .div_sel(div_sel),
    .chan_sel(chan_sel), .cmp_ge(cmp_ge), .sh_ctrl(sh_ctrl),
    .trial_code(trial_code), .chan_out(chan_out), .busy(busy),
    .done(done), .result(result)
  );

  function automatic int exp_busy(input logic [1:0] s, input logic r, input logic [2:0] d);
    return ((4 << s) + 1 + (r ? 10 : 8)) * (int'(d) + 1);
  endfunction

  function automatic logic [9:0] exp_res(input logic [9:0] v, input logic r);
    return r ? v : {2'b00, v[9:2]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic convert(input logic [9:0] v, input logic [1:0] s, input logic r,
                         input logic [2:0] d, input logic [3:0] ch, input bit poke);
    int bc = 0, sc = 0, bad_sh = 0, bad_res = 0, bad_chan = 0;
    logic [9:0] prev = result;
    @(negedge clk);
    vin = v; samp_sel = s; res_sel = r; div_sel = d; chan_sel = ch;
    conv_en = 1'b1; conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    check(busy === 1'b1, "R1 busy after start", busy, 1);
    while (busy === 1'b1 && bc < 2000) begin
      bc++;
      if (sh_ctrl) begin
        sc++;
        if (sc != bc) bad_sh++;
      end
      if (result !== prev) bad_res++;
      if (chan_out !== ch) bad_chan++;
      if (poke && bc == 7) begin
        conv_start = 1'b1; chan_sel = ~ch; samp_sel = ~s; res_sel = ~r;
      end else begin
        conv_start = 1'b0;
      end
      @(negedge clk);
    end
    conv_start = 1'b0;
    check(bc == exp_busy(s, r, d), "R2 busy length", bc, exp_busy(s, r, d));
    check(sc == (4 << s) * (int'(d) + 1) && bad_sh == 0, "R3 sample window", sc, (4 << s) * (int'(d) + 1));
    check(bad_res == 0, "R6 result stable while busy", bad_res, 0);
    check(done === 1'b1, "R6 done with busy fall", done, 1);
    check(result === exp_res(v, r), r ? "R4 10-bit result" : "R5 8-bit result", result, exp_res(v, r));
    check(bad_chan == 0 && chan_out === ch, poke ? "R7 R8 channel held" : "R8 channel held", chan_out, ch);
    @(negedge clk);
    check(done === 1'b0, "R6 done one cycle", done, 0);
    check(busy === 1'b0 && sh_ctrl === 1'b0, "R7 no restart after poke", busy, 0);
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 0 && sh_ctrl === 0 && done === 0, "R9 reset flags", busy, 0);
    check(result === 0 && trial_code === 0 && chan_out === 0, "R9 reset data", result, 0);

    // R1: start without enable
    conv_start = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(busy === 1'b0 && sh_ctrl === 1'b0, "R1 no start without enable", busy, 0);
    end
    conv_start = 1'b0;

    // directed corners
    convert(10'd1023, 2'd2, 1'b1, 3'd0, 4'd5, 1'b0);   // R4 full scale, 16-tick window
    convert(10'd0,    2'd0, 1'b1, 3'd0, 4'd1, 1'b0);   // R4 zero
    convert(10'h2AA,  2'd3, 1'b1, 3'd7, 4'd9, 1'b0);   // R2 max divider
    convert(10'h155,  2'd1, 1'b0, 3'd0, 4'd3, 1'b0);   // R5 8-bit
    convert(10'd1023, 2'd0, 1'b0, 3'd3, 4'd15, 1'b0);  // R5 full scale 8-bit
    convert(10'd3,    2'd0, 1'b0, 3'd0, 4'd2, 1'b0);   // R5 sub-LSB truncation
    convert(10'd512,  2'd2, 1'b1, 3'd1, 4'd6, 1'b1);   // R7 start while busy

    for (int i = 0; i < 150; i++) begin
      if (cycles > 150000) break;
      convert(10'($urandom), 2'($urandom), 1'($urandom), 3'($urandom),
              4'($urandom), ($urandom % 4) == 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles >= 190000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule